// File: doc/BRIEF.md
# Block-Based Table Access Protection Unit

This unit sits beside a small flash program memory and rules on every table access made to it. The program memory is split into a small boot region at the bottom and a row of equal user blocks above it. Each region has three protection flags. A write-lock flag refuses the CPU's table writes. A read-guard flag refuses the CPU's table reads, except when the reading instruction itself lies in the same region. A code-lock flag refuses reads and writes from an external programmer, and has no effect on accesses from the CPU.

For each access the unit takes the target address, the program counter of the instruction making the access, the access direction and its origin (internal or external). It returns a write grant and a masked copy of the raw read data, forced to zero when the read is refused. Both results are combinational, so the check adds no latency. A refused write also raises an error pulse one cycle later.

The unit holds the protection flags itself. Configuration writes can only clear flags. Only a bulk erase requested from the external side sets them all back to 1.

Top module: `tblprot_unit`

## Requirements
- R1: Regions are decoded by target address: boot region 0x000000–0x0001FF (bit 0 of every flag vector), user block 0 at 0x000200–0x001FFF (bit 1), user block 1 at 0x002000–0x003FFF (bit 2) and user block 2 at 0x004000–0x005FFF (bit 3).
- R2: An internal write (`acc_valid`=1, `acc_write`=1, `acc_ext`=0) to a region whose write-lock bit in `prot_wr` is 0 gives `wr_allow`=0. When that bit is 1, it gives `wr_allow`=1.
- R3: An internal read of a region whose read-guard bit in `prot_rd` is 0 is granted only when `acc_pc` decodes to that same region. When the bit is 1, the read is always granted.
- R4: `rd_out` equals `rd_raw` when the read permission for the current address, program counter and origin holds, and is all zeros otherwise. It settles in the same cycle, with no register on the path.
- R5: External accesses (`acc_ext`=1) are granted for both reads and writes exactly when the target region's code-lock bit in `prot_cp` is 1. The code-lock bits do not affect internal accesses.
- R6: `cfg_wr_en`=1 with `cfg_kind` 2'b00 (write-lock), 2'b01 (read-guard) or 2'b10 (code-lock) sets the chosen flag vector to its old value AND `cfg_wdata`. A flag never goes from 0 to 1 through this path. `cfg_kind` 2'b11 changes nothing.
- R7: `erase_req`=1 with `erase_ext`=1 sets every flag to 1 on the next edge. This takes priority over a configuration write in the same cycle.
- R8: `erase_req`=1 with `erase_ext`=0 is ignored and leaves all flags unchanged.
- R9: Addresses at 0x006000 and above belong to no region. Every access to them is granted and their data passes through unchanged.
- R10: After reset all flags read 1 and `wr_err` is 0.
- R11: `wr_err` is 1 in the cycle after a cycle that held a refused write (`acc_valid`=1, `acc_write`=1, `wr_allow`=0), and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is present this cycle |
| acc_write | input | 1 | 1 = table write, 0 = table read |
| acc_ext | input | 1 | 1 = access from the external programmer |
| acc_addr | input | ADDR_W | Target address |
| acc_pc | input | ADDR_W | Program counter of the accessing instruction |
| rd_raw | input | DATA_W | Data read from the array |
| rd_out | output | DATA_W | Read data after masking |
| wr_allow | output | 1 | Write granted |
| wr_err | output | 1 | Refused write in the previous cycle |
| cfg_wr_en | input | 1 | Flag write strobe |
| cfg_kind | input | 2 | Flag vector to write |
| cfg_wdata | input | NUM_USER+1 | Clear mask (0 clears) |
| erase_req | input | 1 | Bulk erase request |
| erase_ext | input | 1 | Erase request comes from the external side |
| prot_wr | output | NUM_USER+1 | Write-lock flags |
| prot_rd | output | NUM_USER+1 | Read-guard flags |
| prot_cp | output | NUM_USER+1 | Code-lock flags |

## Verification
The bench builds the unit with its default parameters: 24-bit addresses, 8-bit data, a 0x200 boot region and three 8 KiB user blocks. Random target addresses and program counters are drawn from 0 to 0x6FFF. This reaches every region edge and the unmapped space above the last block. It also makes same-region and cross-region reads common. Rare random flag writes, with masks that are mostly ones, and rare erase requests from both origins let the flags drift through many mixed states while staying mostly set. Directed cases cover the exact boundary addresses, attempts to set a cleared flag, and an erase that coincides with a flag write.

// File: rtl/tblprot_pkg.sv
package tblprot_pkg;
  typedef enum logic [1:0] {
    KIND_WRLOCK = 2'b00,
    KIND_RDGUARD = 2'b01,
    KIND_CODELOCK = 2'b10,
    KIND_NONE = 2'b11
  } prot_kind_e;

  localparam int unsigned NUM_KINDS = 3;
endpackage

// File: rtl/tblprot_rst_sync.sv
module tblprot_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_core_n = sync_q[1];
endmodule

// File: rtl/tblprot_region_dec.sv
module tblprot_region_dec #(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned BOOT_TOP  = 32'h200,
  parameter int unsigned BLK_SHIFT = 13,
  parameter int unsigned NUM_USER  = 3,
  localparam int unsigned NUM_REG  = NUM_USER + 1,
  localparam int unsigned REG_W    = (NUM_REG > 1) ? $clog2(NUM_REG) : 1,
  localparam int unsigned IDX_W    = ADDR_W - BLK_SHIFT
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [REG_W-1:0]  region,
  output logic              in_map
);
  logic [IDX_W-1:0] blk_idx;
  logic             is_boot;
  logic             is_user;

  assign blk_idx = addr[ADDR_W-1:BLK_SHIFT];
  assign is_boot = (addr < ADDR_W'(BOOT_TOP));
  assign is_user = (blk_idx < IDX_W'(NUM_USER));

  always_comb begin
    region = '0;
    in_map = 1'b0;
    if (is_boot) begin
      region = '0;
      in_map = 1'b1;
    end else if (is_user) begin
      region = REG_W'(blk_idx) + REG_W'(1);
      in_map = 1'b1;
    end
  end
endmodule

// File: rtl/tblprot_flag_store.sv
module tblprot_flag_store
  import tblprot_pkg::*;
#(
  parameter int unsigned NUM_REG = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [1:0]         cfg_kind,
  input  logic [NUM_REG-1:0] cfg_wdata,
  input  logic               erase_req,
  input  logic               erase_ext,
  output logic [NUM_REG-1:0] flags_wr,
  output logic [NUM_REG-1:0] flags_rd,
  output logic [NUM_REG-1:0] flags_cp
);
  logic [NUM_KINDS-1:0][NUM_REG-1:0] flag_q;
  logic [NUM_KINDS-1:0][NUM_REG-1:0] flag_d;
  logic [NUM_KINDS-1:0]              flag_en;
  logic                              erase_go;

  assign erase_go = erase_req & erase_ext;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    logic sel;
    assign sel = cfg_wr_en & (cfg_kind == 2'(k));

    always_comb begin
      flag_en[k] = erase_go | sel;
      if (erase_go) begin
        flag_d[k] = '1;
      end else begin
        flag_d[k] = flag_q[k] & cfg_wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[k] <= '1;
      end else if (flag_en[k]) begin
        flag_q[k] <= flag_d[k];
      end
    end
  end

  assign flags_wr = flag_q[KIND_WRLOCK];
  assign flags_rd = flag_q[KIND_RDGUARD];
  assign flags_cp = flag_q[KIND_CODELOCK];
endmodule

// File: rtl/tblprot_perm.sv
module tblprot_perm #(
  parameter int unsigned NUM_REG = 4,
  localparam int unsigned REG_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
  input  logic [REG_W-1:0]   tgt_region,
  input  logic               tgt_in_map,
  input  logic [REG_W-1:0]   pc_region,
  input  logic               pc_in_map,
  input  logic               ext,
  input  logic [NUM_REG-1:0] flags_wr,
  input  logic [NUM_REG-1:0] flags_rd,
  input  logic [NUM_REG-1:0] flags_cp,
  output logic               rd_ok,
  output logic               wr_ok
);
  logic same_region;
  logic f_wr, f_rd, f_cp;

  assign f_wr = flags_wr[tgt_region];
  assign f_rd = flags_rd[tgt_region];
  assign f_cp = flags_cp[tgt_region];
  assign same_region = pc_in_map & (pc_region == tgt_region);

  always_comb begin
    rd_ok = 1'b1;
    wr_ok = 1'b1;
    if (tgt_in_map) begin
      if (ext) begin
        rd_ok = f_cp;
        wr_ok = f_cp;
      end else begin
        rd_ok = f_rd | same_region;
        wr_ok = f_wr;
      end
    end
  end
endmodule

// File: rtl/tblprot_unit.sv
module tblprot_unit #(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned BOOT_TOP  = 32'h200,
  parameter int unsigned BLK_SHIFT = 13,
  parameter int unsigned NUM_USER  = 3,
  localparam int unsigned NUM_REG  = NUM_USER + 1,
  localparam int unsigned REG_W    = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic               acc_ext,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [ADDR_W-1:0]  acc_pc,
  input  logic [DATA_W-1:0]  rd_raw,
  output logic [DATA_W-1:0]  rd_out,
  output logic               wr_allow,
  output logic               wr_err,
  input  logic               cfg_wr_en,
  input  logic [1:0]         cfg_kind,
  input  logic [NUM_REG-1:0] cfg_wdata,
  input  logic               erase_req,
  input  logic               erase_ext,
  output logic [NUM_REG-1:0] prot_wr,
  output logic [NUM_REG-1:0] prot_rd,
  output logic [NUM_REG-1:0] prot_cp
);
  logic             rst_core_n;
  logic [REG_W-1:0] tgt_region, pc_region;
  logic             tgt_in_map, pc_in_map;
  logic             rd_ok, wr_ok;
  logic             err_d, err_q;

  tblprot_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  tblprot_region_dec #(
    .ADDR_W(ADDR_W), .BOOT_TOP(BOOT_TOP), .BLK_SHIFT(BLK_SHIFT), .NUM_USER(NUM_USER)
  ) u_dec_tgt (
    .addr   (acc_addr),
    .region (tgt_region),
    .in_map (tgt_in_map)
  );

  tblprot_region_dec #(
    .ADDR_W(ADDR_W), .BOOT_TOP(BOOT_TOP), .BLK_SHIFT(BLK_SHIFT), .NUM_USER(NUM_USER)
  ) u_dec_pc (
    .addr   (acc_pc),
    .region (pc_region),
    .in_map (pc_in_map)
  );

  tblprot_flag_store #(.NUM_REG(NUM_REG)) u_flags (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .cfg_wr_en (cfg_wr_en),
    .cfg_kind  (cfg_kind),
    .cfg_wdata (cfg_wdata),
    .erase_req (erase_req),
    .erase_ext (erase_ext),
    .flags_wr  (prot_wr),
    .flags_rd  (prot_rd),
    .flags_cp  (prot_cp)
  );

  tblprot_perm #(.NUM_REG(NUM_REG)) u_perm (
    .tgt_region (tgt_region),
    .tgt_in_map (tgt_in_map),
    .pc_region  (pc_region),
    .pc_in_map  (pc_in_map),
    .ext        (acc_ext),
    .flags_wr   (prot_wr),
    .flags_rd   (prot_rd),
    .flags_cp   (prot_cp),
    .rd_ok      (rd_ok),
    .wr_ok      (wr_ok)
  );

  assign rd_out   = rd_ok ? rd_raw : '0;
  assign wr_allow = acc_valid & acc_write & wr_ok;
  assign err_d    = acc_valid & acc_write & ~wr_ok;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign wr_err = err_q;
endmodule

// File: rtl/tblprot_unit_chk.sv
module tblprot_unit_chk #(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned BOOT_TOP  = 32'h200,
  parameter int unsigned BLK_SHIFT = 13,
  parameter int unsigned NUM_USER  = 3,
  localparam int unsigned NUM_REG  = NUM_USER + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic               acc_write,
  input logic               acc_ext,
  input logic [ADDR_W-1:0]  acc_addr,
  input logic [ADDR_W-1:0]  acc_pc,
  input logic [DATA_W-1:0]  rd_raw,
  input logic [DATA_W-1:0]  rd_out,
  input logic               wr_allow,
  input logic               wr_err,
  input logic               cfg_wr_en,
  input logic               erase_req,
  input logic               erase_ext,
  input logic [NUM_REG-1:0] prot_wr,
  input logic [NUM_REG-1:0] prot_rd,
  input logic [NUM_REG-1:0] prot_cp
);
  localparam logic [ADDR_W:0] MAP_TOP = (ADDR_W+1)'(NUM_USER) << BLK_SHIFT;

  // R2: internal write to a locked boot region is refused
  assert_boot_wrlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && !acc_ext && acc_addr < ADDR_W'(BOOT_TOP) && !prot_wr[0])
      |-> !wr_allow);

  // R3: guarded boot region read from outside it gives zeros
  assert_boot_rdguard_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_ext && acc_addr < ADDR_W'(BOOT_TOP) && acc_pc >= ADDR_W'(BOOT_TOP) && !prot_rd[0])
      |-> (rd_out == '0));

  // R5: with every code-lock flag set, external accesses pass
  assert_ext_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ext && (&prot_cp)) |-> (rd_out == rd_raw && wr_allow == (acc_valid && acc_write)));

  // R6: without an external erase, no flag rises
  assert_one_way_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(erase_req && erase_ext) |=>
      (((prot_wr & ~$past(prot_wr)) == '0) && ((prot_rd & ~$past(prot_rd)) == '0)
       && ((prot_cp & ~$past(prot_cp)) == '0)));

  // R7: external erase restores every flag
  assert_erase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && erase_ext) |=> ((&prot_wr) && (&prot_rd) && (&prot_cp)));

  // R8: internal erase request without config write leaves flags alone
  assert_int_erase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && !erase_ext && !cfg_wr_en) |=>
      ($stable(prot_wr) && $stable(prot_rd) && $stable(prot_cp)));

  // R9: unmapped space passes everything
  assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, acc_addr} >= MAP_TOP) |-> (rd_out == rd_raw && wr_allow == (acc_valid && acc_write)));

  // R11: refused write produces an error pulse on the next cycle
  assert_err_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && !wr_allow) |=> wr_err);

  assert_err_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_write) |=> !wr_err);
endmodule

bind tblprot_unit tblprot_unit_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BOOT_TOP(BOOT_TOP),
  .BLK_SHIFT(BLK_SHIFT), .NUM_USER(NUM_USER)
) chk_i (
  .clk(clk), .rst_n(rst_core_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_ext(acc_ext), .acc_addr(acc_addr), .acc_pc(acc_pc), .rd_raw(rd_raw),
  .rd_out(rd_out), .wr_allow(wr_allow), .wr_err(wr_err), .cfg_wr_en(cfg_wr_en),
  .erase_req(erase_req), .erase_ext(erase_ext), .prot_wr(prot_wr),
  .prot_rd(prot_rd), .prot_cp(prot_cp)
);

// File: tb/tblprot_unit_tb_top.sv
module tblprot_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_write, acc_ext;
  logic [23:0] acc_addr, acc_pc;
  logic [7:0]  rd_raw, rd_out;
  logic        wr_allow, wr_err;
  logic        cfg_wr_en;
  logic [1:0]  cfg_kind;
  logic [3:0]  cfg_wdata;
  logic        erase_req, erase_ext;
  logic [3:0]  prot_wr, prot_rd, prot_cp;

  int n_vec = 0;
  int n_bad = 0;
  logic [3:0] m_wr, m_rd, m_cp;
  logic       exp_err;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  tblprot_unit dut_i (.*);

  function automatic int reg_of(input logic [23:0] a);
    if (a < 24'h000200) return 0;
    if (a < 24'h002000) return 1;
    if (a < 24'h004000) return 2;
    if (a < 24'h006000) return 3;
    return 4;
  endfunction

  function automatic logic exp_rd_ok(input logic [23:0] a, input logic [23:0] pc, input logic ext);
    int t = reg_of(a);
    if (t == 4) return 1'b1;
    if (ext) return m_cp[t];
    return m_rd[t] | (reg_of(pc) == t);
  endfunction

  function automatic logic exp_wr_ok(input logic [23:0] a, input logic ext);
    int t = reg_of(a);
    if (t == 4) return 1'b1;
    if (ext) return m_cp[t];
    return m_wr[t];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic w, input logic ext,
                       input logic [23:0] a, input logic [23:0] pc,
                       input logic cw, input logic [1:0] ck, input logic [3:0] cd,
                       input logic er, input logic ee);
    logic r_ok, w_ok;
    @(negedge clk);
    chk("R11 wr_err", {31'b0, wr_err}, {31'b0, exp_err});
    chk("R6/R7/R8 prot_wr", {28'b0, prot_wr}, {28'b0, m_wr});
    chk("R6/R7/R8 prot_rd", {28'b0, prot_rd}, {28'b0, m_rd});
    chk("R6/R7/R8 prot_cp", {28'b0, prot_cp}, {28'b0, m_cp});
    acc_valid = v; acc_write = w; acc_ext = ext; acc_addr = a; acc_pc = pc;
    rd_raw = 8'($urandom_range(1, 255));
    cfg_wr_en = cw; cfg_kind = ck; cfg_wdata = cd; erase_req = er; erase_ext = ee;
    #1;
    r_ok = exp_rd_ok(a, pc, ext);
    w_ok = exp_wr_ok(a, ext);
    chk("R1-map R3 R4 R5 R9 rd_out", {24'b0, rd_out}, {24'b0, (r_ok ? rd_raw : 8'h00)});
    chk("R2 R5 R9 wr_allow", {31'b0, wr_allow}, {31'b0, v & w & w_ok});
    exp_err = v & w & ~w_ok;
    if (er && ee) begin
      m_wr = '1; m_rd = '1; m_cp = '1;
    end else if (cw) begin
      case (ck)
        2'b00: m_wr = m_wr & cd;
        2'b01: m_rd = m_rd & cd;
        2'b10: m_cp = m_cp & cd;
        default: ;
      endcase
    end
  endtask

  task automatic idle_inputs();
    acc_valid = 0; acc_write = 0; acc_ext = 0; acc_addr = '0; acc_pc = '0; rd_raw = '0;
    cfg_wr_en = 0; cfg_kind = 2'b11; cfg_wdata = '1; erase_req = 0; erase_ext = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    idle_inputs();
    rst_n = 1'b0;
    m_wr = '1; m_rd = '1; m_cp = '1; exp_err = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset prot_wr", {28'b0, prot_wr}, 32'hF);
    chk("R10 reset prot_rd", {28'b0, prot_rd}, 32'hF);
    chk("R10 reset prot_cp", {28'b0, prot_cp}, 32'hF);
    chk("R10 reset wr_err", {31'b0, wr_err}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R9: boundary addresses with all flags open
    apply(1,1,0,24'h0001FF,24'h000000,0,2'b11,4'hF,0,0);
    apply(1,1,0,24'h006000,24'h000000,0,2'b11,4'hF,0,0);
    // R2: lock block 0 writes (bit 1), probe both sides of each edge
    apply(0,0,0,24'h0,24'h0,1,2'b00,4'b1101,0,0);
    apply(1,1,0,24'h000200,24'h000000,0,2'b11,4'hF,0,0);
    apply(1,1,0,24'h0001FF,24'h000000,0,2'b11,4'hF,0,0);
    apply(1,1,0,24'h001FFF,24'h000000,0,2'b11,4'hF,0,0);
    apply(1,1,0,24'h002000,24'h000000,0,2'b11,4'hF,0,0);
    // R3: guard block 1 reads (bit 2); same block pc allowed, other refused
    apply(0,0,0,24'h0,24'h0,1,2'b01,4'b1011,0,0);
    apply(1,0,0,24'h002010,24'h003FFE,0,2'b11,4'hF,0,0);
    apply(1,0,0,24'h002010,24'h001FFE,0,2'b11,4'hF,0,0);
    apply(1,0,0,24'h003FFF,24'h004000,0,2'b11,4'hF,0,0);
    // R5: code-lock block 2 (bit 3): external refused, internal unaffected
    apply(0,0,0,24'h0,24'h0,1,2'b10,4'b0111,0,0);
    apply(1,1,1,24'h004000,24'h0,0,2'b11,4'hF,0,0);
    apply(1,0,1,24'h005FFF,24'h0,0,2'b11,4'hF,0,0);
    apply(1,1,0,24'h005FFF,24'h0,0,2'b11,4'hF,0,0);
    apply(1,0,1,24'h006000,24'h0,0,2'b11,4'hF,0,0);
    // R6: attempt to set cleared bits, and kind 11 has no effect
    apply(0,0,0,24'h0,24'h0,1,2'b00,4'hF,0,0);
    apply(0,0,0,24'h0,24'h0,1,2'b11,4'h0,0,0);
    // R8: internal erase ignored
    apply(0,0,0,24'h0,24'h0,0,2'b11,4'hF,1,0);
    // R7: external erase beats a same-cycle clear
    apply(0,0,0,24'h0,24'h0,1,2'b01,4'h0,1,1);
    apply(1,1,1,24'h004000,24'h0,0,2'b11,4'hF,0,0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic cw, er;
      cw = ($urandom_range(0, 29) == 0);
      er = ($urandom_range(0, 149) == 0);
      apply($urandom_range(0, 3) != 0, 1'($urandom), ($urandom_range(0, 3) == 0),
            24'($urandom_range(0, 24'h6FFF)), 24'($urandom_range(0, 24'h6FFF)),
            cw, 2'($urandom), 4'($urandom | $urandom), er, 1'($urandom));
    end
    apply(0,0,0,24'h0,24'h0,0,2'b11,4'hF,0,0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule